// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is a small general-purpose I/O port with eight lines. It drives a pad output value and a pad output-enable for each line, and it samples the pad inputs through a synchronizer. Software reaches it over a byte-wide register bus with valid, write, address and data signals and no wait states. A read returns its data combinationally in the same cycle. A write takes effect at the next clock edge.

Every data access lands in a window of addresses below the direction register. Address bits 9 down to 2 act as a per-line mask, so one store can change a chosen subset of lines and leave the rest untouched, with no read-modify-write. A stored value is kept only for lines that are already outputs. To set a line to a known level, software first switches the line to output and then writes the data again.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every line is an input: pad_oe is 0, pad_out is 0, and a read of the direction register returns 0.
- R2: The direction register sits at byte offset 0x400. It is read/write, and a bit value of 1 makes that line an output.
- R3: A write to an address below 0x400 updates line n only when address bit n+2 is set. Lines whose mask bit is clear keep their output value.
- R4: A data write leaves no trace on a line that is an input at the time of the write. When that line later becomes an output, it drives its earlier value.
- R5: A read below 0x400 returns 0 on every bit whose mask bit (address bit n+2) is clear.
- R6: For a masked line, a data read returns the driven value if the line is an output, and the synchronized pad value if the line is an input.
- R7: A change on pad_in reaches data reads after exactly two rising clock edges. After one edge the read still shows the old value.
- R8: Any address that is neither below 0x400 nor equal to 0x400 reads as 0, and a write to it changes neither pad_out nor pad_oe nor the direction register.
- R9: pad_oe equals the direction register bit for bit at all times.
- R10: bus_rdata is 0 whenever bus_valid is low or bus_write is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 8 | Write data, one bit per line |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 drives the pad |

## Verification
The assertions assume that every access is complete within one cycle, with bus_addr, bus_write and bus_wdata steady while bus_valid is high. They also assume that only the bus changes pad_out and pad_oe. The bench drives every bus signal at the falling edge and holds it across the following rising edge. It changes pad_in only at a falling edge. After a pad change it idles the bus for three cycles before it compares any input-line read against its model, so the model never has to predict a synchronizer half-way through an update.

// File: rtl/gpio_mask_port_pkg.sv
package gpio_mask_port_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_DIR  = 2'd2,
      ACC_VOID = 2'd3
   } gm_access_e;

endpackage

// File: rtl/gpio_mask_port_sync.sv
module gpio_mask_port_sync #(
   parameter int LINES  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] async_in,
   output logic [LINES-1:0] sync_out
);

   if (STAGES < 0) begin : g_bad_stages
      $error("gpio_mask_port_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign sync_out = async_in;
   end else begin : g_chain
      logic [LINES-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end

      assign sync_out = stage_q[STAGES-1];
   end

endmodule

// File: rtl/gpio_mask_port_decode.sv
module gpio_mask_port_decode
   import gpio_mask_port_pkg::*;
#(
   parameter int              LINES      = 8,
   parameter int              ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] DIR_OFFSET = 'h400
) (
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   output gm_access_e        access,
   output logic [LINES-1:0]  line_mask
);

   localparam int MASK_LO = 2;
   localparam int MASK_HI = MASK_LO + LINES - 1;

   if ((64'd1 << (MASK_HI + 1)) > 64'(DIR_OFFSET)) begin : g_bad_window
      $error("gpio_mask_port_decode: mask bits overlap the direction offset");
   end

   assign line_mask = bus_addr[MASK_HI:MASK_LO];

   always_comb begin
      if (!bus_valid)                access = ACC_IDLE;
      else if (bus_addr < DIR_OFFSET) access = ACC_DATA;
      else if (bus_addr == DIR_OFFSET) access = ACC_DIR;
      else                           access = ACC_VOID;
   end

endmodule

// File: rtl/gpio_mask_port_regs.sv
module gpio_mask_port_regs #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_data,
   input  logic [LINES-1:0] line_mask,
   input  logic [LINES-1:0] wdata,
   output logic [LINES-1:0] dir_q,
   output logic [LINES-1:0] out_q
);

   logic [LINES-1:0] upd;

   assign upd = line_mask & dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_dir) begin
         dir_q <= wdata;
      end
   end

   for (genvar n = 0; n < LINES; n++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q[n] <= 1'b0;
         end else if (wr_data && upd[n]) begin
            out_q[n] <= wdata[n];
         end
      end
   end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_mask_port_pkg::*;
#(
   parameter int                LINES       = 8,
   parameter int                ADDR_W      = 12,
   parameter logic [ADDR_W-1:0] DIR_OFFSET  = 'h400,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [LINES-1:0]  bus_wdata,
   output logic [LINES-1:0]  bus_rdata,
   input  logic [LINES-1:0]  pad_in,
   output logic [LINES-1:0]  pad_out,
   output logic [LINES-1:0]  pad_oe
);

   if (LINES < 1) begin : g_bad_lines
      $error("gpio_mask_port: LINES must be at least 1");
   end
   if (ADDR_W < LINES + 3) begin : g_bad_addr
      $error("gpio_mask_port: ADDR_W too narrow for mask and direction offset");
   end

   gm_access_e       access;
   logic [LINES-1:0] line_mask;
   logic [LINES-1:0] dir_q;
   logic [LINES-1:0] out_q;
   logic [LINES-1:0] pad_sync;
   logic [LINES-1:0] line_val;

   gpio_mask_port_decode #(
      .LINES      (LINES),
      .ADDR_W     (ADDR_W),
      .DIR_OFFSET (DIR_OFFSET)
   ) u_decode (
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .access    (access),
      .line_mask (line_mask)
   );

   gpio_mask_port_regs #(
      .LINES (LINES)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_dir    (bus_write && access == ACC_DIR),
      .wr_data   (bus_write && access == ACC_DATA),
      .line_mask (line_mask),
      .wdata     (bus_wdata),
      .dir_q     (dir_q),
      .out_q     (out_q)
   );

   gpio_mask_port_sync #(
      .LINES  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pad_sync)
   );

   assign line_val = (dir_q & out_q) | (~dir_q & pad_sync);

   always_comb begin
      bus_rdata = '0;
      if (!bus_write) begin
         case (access)
            ACC_DATA: bus_rdata = line_mask & line_val;
            ACC_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign pad_out = out_q;
   assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
   parameter int                LINES      = 8,
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] DIR_OFFSET = 'h400
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [LINES-1:0]  bus_wdata,
   input logic [LINES-1:0]  bus_rdata,
   input logic [LINES-1:0]  pad_out,
   input logic [LINES-1:0]  pad_oe
);

   logic [LINES-1:0] mask;
   logic             in_data;
   logic             is_dir;
   logic [LINES-1:0] may_change;

   assign mask       = bus_addr[LINES+1:2];
   assign in_data    = bus_addr < DIR_OFFSET;
   assign is_dir     = bus_addr == DIR_OFFSET;
   assign may_change = (bus_valid && bus_write && in_data) ? (mask & pad_oe) : '0;

   // R2
   a_r2_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && is_dir) |=> (pad_oe == $past(bus_wdata)));

   // R3 R4 R8: pad_out bits move only where a masked write hit an output line
   a_r3_only_masked_outputs_move: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pad_out ^ $past(pad_out)) & ~$past(may_change)) == '0));

   // R8: direction changes only through its own address
   a_r8_dir_only_by_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write && is_dir) |=> $stable(pad_oe));

   a_r8_void_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && !in_data && !is_dir) |-> (bus_rdata == '0));

   a_r5_unmasked_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && in_data) |-> ((bus_rdata & ~mask) == '0));

   a_r6_output_lines_read_back: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && in_data) |-> ((bus_rdata & pad_oe) == (pad_out & mask & pad_oe)));

   a_r10_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_valid || bus_write) |-> (bus_rdata == '0));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
   .LINES      (LINES),
   .ADDR_W     (ADDR_W),
   .DIR_OFFSET (DIR_OFFSET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_port_test.sv
`timescale 1ns/1ps
module gpio_mask_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pad_in = '0;
   logic [7:0]  pad_out;
   logic [7:0]  pad_oe;

   int checks = 0;
   int failures = 0;
   logic [7:0] dir_m = '0;
   logic [7:0] out_m = '0;
   logic [7:0] pad_m = '0;
   logic [7:0] rd;

   always #5 clk = ~clk;

   gpio_mask_port uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   function automatic logic [11:0] data_addr(logic [7:0] m);
      return {2'b00, m, 2'b00};
   endfunction

   function automatic logic [7:0] exp_read(logic [7:0] m);
      return m & ((dir_m & out_m) | (~dir_m & pad_m));
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_valid = 1'b0;
         bus_write = 1'b0;
      end
   endtask

   task automatic bus_wr(logic [11:0] a, logic [7:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(logic [11:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic model_data_wr(logic [7:0] m, logic [7:0] d);
      out_m = (out_m & ~(m & dir_m)) | (d & m & dir_m);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      pad_in = 8'hA5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pad_m = 8'hA5;
      idle(3);

      // R1 reset state
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 pad_out", pad_out, 8'h00);
      bus_rd(12'h400, rd);
      check("R1 dir read", rd, 8'h00);

      // R4 write to input lines is dropped
      bus_wr(data_addr(8'hFF), 8'hFF);
      model_data_wr(8'hFF, 8'hFF);
      check("R4 pad_out after input write", pad_out, 8'h00);
      bus_wr(12'h400, 8'h0F);
      dir_m = 8'h0F;
      check("R4 pad_out after switch", pad_out, 8'h00);
      check("R9 pad_oe", pad_oe, 8'h0F);
      bus_rd(12'h400, rd);
      check("R2 dir read", rd, 8'h0F);

      // R6 mixed read: outputs low nibble = 0, inputs high nibble = pad
      bus_rd(data_addr(8'hFF), rd);
      check("R6 mixed read", rd, 8'hA0);

      // R3 masked write: lines 0 and 2 only
      bus_wr(12'h014, 8'hFF);
      model_data_wr(8'h05, 8'hFF);
      check("R3 masked write", pad_out, 8'h05);
      bus_wr(data_addr(8'h0A), 8'h00);
      model_data_wr(8'h0A, 8'h00);
      check("R3 unmasked lines kept", pad_out, 8'h05);

      // R5 unmasked bits read zero
      bus_rd(12'h004, rd);
      check("R5 single mask", rd, 8'h01);
      bus_rd(12'h000, rd);
      check("R5 empty mask", rd, 8'h00);
      bus_rd(data_addr(8'hF0), rd);
      check("R5 R6 input nibble", rd, 8'hA0);

      // R7 synchronizer latency
      idle(1);
      @(negedge clk);
      pad_in = 8'h5A;
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = data_addr(8'hF0);
      @(negedge clk);
      #1;
      check("R7 after one edge", bus_rdata, 8'hA0);
      @(negedge clk);
      #1;
      check("R7 after two edges", bus_rdata, 8'h50);
      pad_m = 8'h5A;

      // R8 undefined offsets
      bus_wr(12'h404, 8'hFF);
      bus_wr(12'h800, 8'hFF);
      bus_wr(12'h401, 8'hFF);
      check("R8 pad_oe unchanged", pad_oe, dir_m);
      check("R8 pad_out unchanged", pad_out, out_m);
      bus_rd(12'h404, rd);
      check("R8 read 0x404", rd, 8'h00);
      bus_rd(12'hFFC, rd);
      check("R8 read 0xFFC", rd, 8'h00);
      bus_rd(12'h400, rd);
      check("R8 dir intact", rd, dir_m);

      // R10 no read data without a read
      idle(1);
      #1;
      check("R10 idle rdata", bus_rdata, 8'h00);

      // random phase
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [7:0] m;
         logic [7:0] d;
         op = $urandom_range(0, 5);
         m  = 8'($urandom);
         d  = 8'($urandom);
         case (op)
            0: begin
               bus_wr(12'h400, d);
               dir_m = d;
               check("R9 random dir", pad_oe, dir_m);
               check("R4 random dir out", pad_out, out_m);
            end
            1, 2: begin
               bus_wr(data_addr(m), d);
               model_data_wr(m, d);
               check("R3 random write", pad_out, out_m);
            end
            3, 4: begin
               bus_rd(data_addr(m), rd);
               check("R6 random read", rd, exp_read(m));
            end
            default: begin
               @(negedge clk);
               bus_valid = 1'b0;
               pad_in = d;
               idle(3);
               pad_m = d;
               bus_rd(12'h400, rd);
               check("R2 random dir read", rd, dir_m);
            end
         endcase
      end

      idle(2);
      finish_run();
   end

endmodule